// File: doc/BRIEF.md
# Scatter-Gather Audio DMA Engine

This block is a bus-master DMA controller that moves audio sample bytes between system memory and a byte stream. Software builds a table of descriptors in memory. Each descriptor is two 32-bit words: the first holds a byte base address, and the second holds a byte count in its low bits and control flags in its top bits. Software loads the table address into a pointer register, picks a transfer direction, and sets a start bit. The engine then walks the table on its own.

For each descriptor, the engine reads the two words, advances the pointer by 8, and moves the counted bytes one at a time. In the memory-to-stream direction it reads each byte and offers it on the outbound stream. In the stream-to-memory direction it takes each byte from the inbound stream and writes it to memory. Three flags control the walk: a jump entry redirects the walk to another table address, an end-of-page entry raises a sticky status flag, and an end-of-table entry stops the engine. A zero count or a failed memory response raises an error flag and halts the engine.

The memory side is a single-outstanding request/response port, and both stream sides use a valid/ready handshake.

Top module: `sgdma_engine`

## Requirements
- R1: After synchronous reset, the command, status and pointer registers all read zero, and mem_req, out_valid and in_ready are low.
- R2: Registers are addressed by reg_sel: 0 is command (bit 0 start, bit 3 direction, all other bits read zero), 1 is status (bit 0 end-of-page, bit 1 error, each cleared by writing 1 to it), and 2 is the 32-bit pointer.
- R3: A command write with bit 0 set while the engine is idle starts a table walk. The engine reads the word at the pointer (the base address) and then the word at pointer+4 (count in bits 15:0, jump in bit 29, end-of-page in bit 30, end-of-table in bit 31).
- R4: Each successful count-word read advances the pointer register by 8, so it reads back as the address of the next descriptor.
- R5: With direction 0, byte i of a descriptor (i from 0 to count-1) is read from base+i, taken from mem_rdata[7:0], and presented on out_data in order. out_data holds stable while out_valid waits for out_ready.
- R6: With direction 1, bytes accepted from the inbound stream are written in order to base+i, in mem_wdata[7:0] with the upper bits zero.
- R7: A descriptor with the jump flag moves no data. The pointer is loaded with its base word and the next descriptor is read from there. The count and the other flags of a jump entry are ignored.
- R8: Completing a descriptor whose end-of-page flag is set sets status bit 0. The bit stays set until software writes 1 to it; a write of 0 leaves it set.
- R9: After completing a descriptor whose end-of-table flag is set, the engine issues no memory request until a new start write.
- R10: A zero count in a non-jump descriptor, or mem_err on any response, sets status bit 1 and halts the engine with no further memory requests. The pointer advances only on a successful count-word read.
- R11: While the engine is busy, writes to the command and pointer registers have no effect.
- R12: At most one memory request is outstanding. mem_req holds mem_addr, mem_we and mem_wdata stable until mem_ready accepts it, and the next request waits for mem_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 command, 1 status, 2 pointer) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data (byte in bits 7:0) |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Response valid |
| mem_rdata | input | 32 | Response read data |
| mem_err | input | 1 | Response carries an error |
| out_valid | output | 1 | Outbound byte valid |
| out_data | output | 8 | Outbound byte |
| out_ready | input | 1 | Outbound sink accepts the byte |
| in_valid | input | 1 | Inbound byte valid |
| in_data | input | 8 | Inbound byte |
| in_ready | output | 1 | Engine accepts the inbound byte |

## Verification
The bench targets the pointer arithmetic around jump entries. A design that added 8 after a jump, or that moved data for one, would show a wrong next descriptor address or spurious byte reads in the compared access stream. A count-word or data-read error must stop the walk with the pointer at the right value; a design that kept walking would issue accesses the model does not expect. The bench also tries to change the command and pointer mid-run, and checks end-of-page stickiness against writes of 0 and of 1. A design that let those writes through would change direction or jump to a wrong table, and a design that cleared the flag on any write would lose the page event.

// File: rtl/sgdma_pkg.sv
// Shared constants and types for the scatter-gather DMA engine.
// Assumes 32-bit descriptor words and byte-granular data moves.
package sgdma_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned FLAG_EOT = 31;
    localparam int unsigned FLAG_EOP = 30;
    localparam int unsigned FLAG_JMP = 29;
    localparam int unsigned CMD_GO   = 0;
    localparam int unsigned CMD_DIR  = 3;
    localparam logic [1:0]  SEL_CMD  = 2'd0;
    localparam logic [1:0]  SEL_STAT = 2'd1;
    localparam logic [1:0]  SEL_PTR  = 2'd2;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FA, ST_FAW, ST_FC, ST_FCW,
        ST_RD, ST_RDW, ST_OUT, ST_IN, ST_WR, ST_WRW, ST_DONE
    } seq_state_t;
endpackage

// File: rtl/sgdma_regs.sv
// Software-visible registers: command, sticky status, descriptor pointer.
// Assumes the sequencer loads the pointer only while busy; software
// writes to command and pointer are dropped while busy.
module sgdma_regs
    import sgdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_ld_val,
    input  logic              eop_set,
    input  logic              err_set,
    output logic              start,
    output logic              dir_q,
    output logic [ADDR_W-1:0] ptr_q,
    output logic              stat_eop,
    output logic              stat_err
);
    logic go_q;
    logic wr_cmd, wr_stat, wr_ptr;

    assign wr_cmd  = reg_wr_en && (reg_sel == SEL_CMD);
    assign wr_stat = reg_wr_en && (reg_sel == SEL_STAT);
    assign wr_ptr  = reg_wr_en && (reg_sel == SEL_PTR);
    assign start   = wr_cmd && !busy && reg_wdata[CMD_GO];

    // Command register: start and direction bits, frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q  <= 1'b0;
            dir_q <= 1'b0;
        end else if (wr_cmd && !busy) begin
            go_q  <= reg_wdata[CMD_GO];
            dir_q <= reg_wdata[CMD_DIR];
        end
    end

    // Pointer register: software load when idle, engine update when busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr_ptr && !busy) begin
            ptr_q <= reg_wdata[ADDR_W-1:0];
        end else if (ptr_ld) begin
            ptr_q <= ptr_ld_val;
        end
    end

    // Status flags: set by the engine, cleared by writing one; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_eop <= 1'b0;
            stat_err <= 1'b0;
        end else begin
            stat_eop <= eop_set | (stat_eop & ~(wr_stat & reg_wdata[0]));
            stat_err <= err_set | (stat_err & ~(wr_stat & reg_wdata[1]));
        end
    end

    // Read mux for the selected register.
    always_comb begin
        case (reg_sel)
            SEL_CMD:  reg_rdata = {{(DATA_W-4){1'b0}}, dir_q, 2'b00, go_q};
            SEL_STAT: reg_rdata = {{(DATA_W-2){1'b0}}, stat_err, stat_eop};
            SEL_PTR:  reg_rdata = DATA_W'(ptr_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sgdma_bytecnt.sv
// Data-phase byte address and remaining-count tracker.
// Assumes load and step never coincide; step only while bytes remain.
module sgdma_bytecnt #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  len,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last
);
    logic [CNT_W-1:0] rem_q;

    // Address and remaining count, loaded per descriptor, stepped per byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem_q    <= '0;
        end else if (load) begin
            cur_addr <= base;
            rem_q    <= len;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_W'(1);
            rem_q    <= rem_q - CNT_W'(1);
        end
    end

    assign last = (rem_q == CNT_W'(1));
endmodule

// File: rtl/sgdma_seq.sv
// Table-walk sequencer: fetches descriptor words, drives data moves in
// either direction, and raises page and error events. Assumes a memory
// port that answers each accepted request with exactly one response.
module sgdma_seq
    import sgdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir,
    input  logic [ADDR_W-1:0] ptr,
    output logic              ptr_ld,
    output logic [ADDR_W-1:0] ptr_ld_val,
    output logic              eop_set,
    output logic              err_set,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              cnt_load,
    output logic [ADDR_W-1:0] cnt_base,
    output logic [CNT_W-1:0]  cnt_len,
    output logic              cnt_step,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic              cnt_last
);
    seq_state_t        state;
    logic [ADDR_W-1:0] base_q;
    logic              eop_f, eot_f;
    logic [BYTE_W-1:0] byte_q;
    logic              waiting, resp_ok, resp_bad, jmp, zero_cnt;

    assign resp_ok  = mem_rvalid && !mem_err;
    assign resp_bad = mem_rvalid && mem_err;
    assign jmp      = mem_rdata[FLAG_JMP];
    assign zero_cnt = !jmp && (mem_rdata[CNT_W-1:0] == '0);
    assign waiting  = (state == ST_FAW) || (state == ST_FCW) ||
                      (state == ST_RDW) || (state == ST_WRW);

    // Event and counter controls decoded from state and responses.
    always_comb begin
        err_set    = (waiting && resp_bad) || (state == ST_FCW && resp_ok && zero_cnt);
        ptr_ld     = (state == ST_FCW) && resp_ok;
        ptr_ld_val = jmp ? base_q : ptr + ADDR_W'(8);
        cnt_load   = (state == ST_FCW) && resp_ok && !jmp && !zero_cnt;
        cnt_base   = base_q;
        cnt_len    = mem_rdata[CNT_W-1:0];
        cnt_step   = (state == ST_OUT && out_ready) || (state == ST_WRW && resp_ok);
        eop_set    = (state == ST_DONE) && eop_f;
        busy       = (state != ST_IDLE);
    end

    // Memory and stream port drive from the current state.
    always_comb begin
        mem_req   = (state == ST_FA) || (state == ST_FC) ||
                    (state == ST_RD) || (state == ST_WR);
        mem_we    = (state == ST_WR);
        mem_wdata = DATA_W'(byte_q);
        case (state)
            ST_FA:   mem_addr = ptr;
            ST_FC:   mem_addr = ptr + ADDR_W'(4);
            default: mem_addr = cur_addr;
        endcase
        out_valid = (state == ST_OUT);
        out_data  = byte_q;
        in_ready  = (state == ST_IN);
    end

    // Walk state machine with descriptor and byte holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            base_q <= '0;
            eop_f  <= 1'b0;
            eot_f  <= 1'b0;
            byte_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= ST_FA;
                ST_FA:   if (mem_ready) state <= ST_FAW;
                ST_FAW:  if (mem_rvalid) begin
                    if (mem_err) state <= ST_IDLE;
                    else begin
                        base_q <= mem_rdata[ADDR_W-1:0];
                        state  <= ST_FC;
                    end
                end
                ST_FC:   if (mem_ready) state <= ST_FCW;
                ST_FCW:  if (mem_rvalid) begin
                    if (mem_err || zero_cnt) state <= ST_IDLE;
                    else if (jmp) state <= ST_FA;
                    else begin
                        eop_f <= mem_rdata[FLAG_EOP];
                        eot_f <= mem_rdata[FLAG_EOT];
                        state <= dir ? ST_IN : ST_RD;
                    end
                end
                ST_RD:   if (mem_ready) state <= ST_RDW;
                ST_RDW:  if (mem_rvalid) begin
                    if (mem_err) state <= ST_IDLE;
                    else begin
                        byte_q <= mem_rdata[BYTE_W-1:0];
                        state  <= ST_OUT;
                    end
                end
                ST_OUT:  if (out_ready) state <= cnt_last ? ST_DONE : ST_RD;
                ST_IN:   if (in_valid) begin
                    byte_q <= in_data;
                    state  <= ST_WR;
                end
                ST_WR:   if (mem_ready) state <= ST_WRW;
                ST_WRW:  if (mem_rvalid) state <= mem_err ? ST_IDLE : (cnt_last ? ST_DONE : ST_IN);
                ST_DONE: state <= eot_f ? ST_IDLE : ST_FA;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sgdma_engine.sv
// Top of the scatter-gather DMA engine: registers, walk sequencer and
// byte counter. Assumes a single-outstanding memory port and byte streams.
module sgdma_engine
    import sgdma_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready
);
    logic              busy, start, dir_q, ptr_ld, eop_set, err_set;
    logic              stat_eop, stat_err;
    logic [ADDR_W-1:0] ptr_q, ptr_ld_val;
    logic              cnt_load, cnt_step, cnt_last;
    logic [ADDR_W-1:0] cnt_base, cur_addr;
    logic [CNT_W-1:0]  cnt_len;

    sgdma_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val), .eop_set(eop_set),
        .err_set(err_set), .start(start), .dir_q(dir_q), .ptr_q(ptr_q),
        .stat_eop(stat_eop), .stat_err(stat_err)
    );

    sgdma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir_q), .ptr(ptr_q),
        .ptr_ld(ptr_ld), .ptr_ld_val(ptr_ld_val), .eop_set(eop_set),
        .err_set(err_set), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .cnt_load(cnt_load), .cnt_base(cnt_base), .cnt_len(cnt_len),
        .cnt_step(cnt_step), .cur_addr(cur_addr), .cnt_last(cnt_last)
    );

    sgdma_bytecnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .base(cnt_base),
        .len(cnt_len), .step(cnt_step), .cur_addr(cur_addr), .last(cnt_last)
    );
endmodule

// File: rtl/sgdma_engine_chk.sv
// Protocol and status checker for sgdma_engine, attached by bind.
module sgdma_engine_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rvalid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              in_ready,
    input logic              reg_wr_en,
    input logic [1:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              stat_eop,
    input logic              stat_err
);
    logic outstanding;

    // Tracks an accepted request that has not yet been answered.
    always_ff @(posedge clk) begin
        if (!rst_n) outstanding <= 1'b0;
        else if (mem_req && mem_ready) outstanding <= 1'b1;
        else if (mem_rvalid) outstanding <= 1'b0;
    end

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R12
    single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !mem_req);

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R5
    one_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, out_valid, in_ready}));

    // R8
    eop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_eop) |-> $past(reg_wr_en && reg_sel == 2'd1 && reg_wdata[0]));

    // R10
    err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_err) |-> !mem_req && !out_valid && !in_ready);
endmodule

bind sgdma_engine sgdma_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .in_ready(in_ready), .reg_wr_en(reg_wr_en),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .stat_eop(stat_eop),
    .stat_err(stat_err)
);

// File: tb/sgdma_engine_tb_top.sv
`timescale 1ns/1ps
module sgdma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready = 1'b0, mem_rvalid = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        in_valid = 1'b0, in_ready;
    logic [7:0]  in_data = '0;

    sgdma_engine dut_i (.*);

    initial forever #2.5 clk = ~clk;

    typedef struct { bit we; int unsigned addr; byte unsigned wd; } acc_t;
    byte unsigned mem [int unsigned];
    acc_t         exp_acc[$];
    byte unsigned exp_out[$];
    byte unsigned in_src[$];
    byte unsigned in_model[$];
    int unsigned  exp_ptr;
    bit           exp_eop, exp_err;
    bit           err_en = 0;
    int unsigned  err_addr = 0;
    int           stall = 0;
    int           checks = 0, errors = 0;
    int           cyc = 0;
    string        cur_tag = "R1";

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic byte unsigned rdb(int unsigned a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    function automatic logic [31:0] rdw(int unsigned a);
        return {rdb(a + 3), rdb(a + 2), rdb(a + 1), rdb(a)};
    endfunction

    task automatic put_word(int unsigned a, logic [31:0] w);
        for (int i = 0; i < 4; i++) mem[a + i] = w[8*i +: 8];
    endtask

    task automatic put_desc(int unsigned a, int unsigned base, logic [31:0] cw);
        put_word(a, base);
        put_word(a + 4, cw);
    endtask

    task automatic push_acc(bit we, int unsigned a, byte unsigned d);
        acc_t x;
        x.we = we; x.addr = a; x.wd = d;
        exp_acc.push_back(x);
    endtask

    function automatic bit hit_err(int unsigned a);
        return err_en && (a == err_addr);
    endfunction

    // Behavioural table walk producing the expected access and byte streams.
    task automatic model_run(int unsigned p0, bit dir);
        int unsigned p = p0, base, a;
        logic [31:0] cw;
        int k = 0, guard = 0;
        bit stop = 0;
        exp_eop = 0; exp_err = 0;
        while (!stop && guard < 64) begin
            guard++;
            push_acc(0, p, 0);
            if (hit_err(p)) begin exp_err = 1; break; end
            base = rdw(p);
            push_acc(0, p + 4, 0);
            if (hit_err(p + 4)) begin exp_err = 1; break; end
            cw = rdw(p + 4);
            if (cw[29]) begin p = base; continue; end
            p = p + 8;
            if (cw[15:0] == 0) begin exp_err = 1; break; end
            for (int i = 0; i < int'(cw[15:0]); i++) begin
                a = base + i;
                if (!dir) begin
                    push_acc(0, a, 0);
                    if (hit_err(a)) begin exp_err = 1; stop = 1; break; end
                    exp_out.push_back(rdb(a));
                end else begin
                    push_acc(1, a, in_model[k]);
                    k++;
                    if (hit_err(a)) begin exp_err = 1; stop = 1; break; end
                end
            end
            if (stop) break;
            if (cw[30]) exp_eop = 1;
            if (cw[31]) stop = 1;
        end
        exp_ptr = p;
    endtask

    task automatic wr_reg(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    // Memory responder: checks each accepted request and answers it.
    initial begin
        acc_t e;
        int unsigned a;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0; mem_err = 1'b0;
            mem_ready = (stall == 0) ? 1'b1 : ($urandom_range(0, 2) != 0);
            if (rst_n && mem_req && mem_ready) begin
                a = mem_addr;
                if (exp_acc.size() == 0) begin
                    chk(0, "R9/R10", {cur_tag, " unexpected access"}, a, 0);
                end else begin
                    e = exp_acc.pop_front();
                    chk(mem_addr == e.addr, "R3/R12", {cur_tag, " access address"}, a, e.addr);
                    chk(mem_we == e.we, "R12", {cur_tag, " access direction"}, mem_we, e.we);
                    if (e.we) chk(mem_wdata == {24'h0, e.wd}, "R6", {cur_tag, " write data"}, mem_wdata, e.wd);
                end
                if (mem_we) mem[a] = mem_wdata[7:0];
                @(negedge clk);
                mem_ready = 1'b0;
                repeat ($urandom_range(0, stall)) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = rdw(a);
                mem_err    = hit_err(a);
            end
        end
    end

    // Outbound sink: compares each accepted byte with the model stream.
    initial begin
        byte unsigned e;
        forever begin
            @(negedge clk);
            out_ready = (stall == 0) ? 1'b1 : ($urandom_range(0, 3) == 0);
            if (rst_n && out_valid && out_ready) begin
                if (exp_out.size() == 0) chk(0, "R5", "unexpected out byte", out_data, 0);
                else begin
                    e = exp_out.pop_front();
                    chk(out_data == e, "R5", {cur_tag, " out byte"}, out_data, e);
                end
            end
        end
    end

    // Inbound source: presents queued bytes and holds each until accepted.
    initial begin
        bit hs = 0;
        forever begin
            @(negedge clk);
            if (hs) void'(in_src.pop_front());
            if (!in_valid || hs) begin
                if (in_src.size() != 0 && (stall == 0 || $urandom_range(0, 1) == 0)) begin
                    in_valid = 1'b1; in_data = in_src[0];
                end else in_valid = 1'b0;
            end
            hs = in_valid && in_ready;
        end
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                finish_sim();
            end
        end
    end

    // Starts a walk, waits for the model streams to drain, checks the end state.
    task automatic run_walk(int unsigned p0, bit dir, string tag);
        logic [31:0] v;
        int t = 0, reqs = 0;
        cur_tag = tag;
        in_model = in_src;
        model_run(p0, dir);
        wr_reg(2'd2, p0);
        wr_reg(2'd0, dir ? 32'h9 : 32'h1);
        while ((exp_acc.size() != 0 || exp_out.size() != 0) && t < 20000) begin
            @(negedge clk); t++;
        end
        chk(t < 20000, tag, "walk completed", t, 0);
        @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (mem_req) reqs++;
        end
        chk(reqs == 0, "R9/R10", {tag, " no request after halt"}, reqs, 0);
        rd_reg(2'd1, v);
        chk(v == {30'h0, exp_err, exp_eop}, "R8/R10", {tag, " status"}, v, {exp_err, exp_eop});
        rd_reg(2'd2, v);
        chk(v == exp_ptr, "R4", {tag, " pointer"}, v, exp_ptr);
        rd_reg(2'd0, v);
        chk(v == (dir ? 32'h9 : 32'h1), "R2", {tag, " command readback"}, v, dir ? 9 : 1);
    endtask

    initial begin
        logic [31:0] v;
        for (int a = 32'h1000; a < 32'h1400; a++) mem[a] = a[7:0] ^ 8'h5A;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_reg(2'd0, v); chk(v == 0, "R1", "command after reset", v, 0);
        rd_reg(2'd1, v); chk(v == 0, "R1", "status after reset", v, 0);
        rd_reg(2'd2, v); chk(v == 0, "R1", "pointer after reset", v, 0);
        chk({mem_req, out_valid, in_ready} == 0, "R1", "outputs after reset", {mem_req, out_valid, in_ready}, 0);

        // R2 reserved command bits; start bit clear does not start
        wr_reg(2'd0, 32'hFE);
        rd_reg(2'd0, v); chk(v == 32'h8, "R2", "reserved bits read zero", v, 8);
        repeat (10) @(negedge clk);
        chk(mem_req == 0, "R3", "no walk without start bit", mem_req, 0);
        wr_reg(2'd0, 32'h0);

        // R5 R8 R9: three-entry read walk, page mark on the middle entry
        put_desc(32'h100, 32'h1000, 32'h0000_0003);
        put_desc(32'h108, 32'h1100, 32'h4000_0001);
        put_desc(32'h110, 32'h1200, 32'h8000_0004);
        run_walk(32'h100, 0, "R5");
        chk(exp_ptr == 32'h118, "R4", "model pointer sanity", exp_ptr, 32'h118);
        wr_reg(2'd1, 32'h0);
        rd_reg(2'd1, v); chk(v == 32'h1, "R8", "page flag kept on write of 0", v, 1);
        wr_reg(2'd1, 32'h1);
        rd_reg(2'd1, v); chk(v == 32'h0, "R8", "page flag cleared by write of 1", v, 0);

        // R7 jump entry, with stalls
        stall = 3;
        put_desc(32'h200, 32'h1300, 32'h0000_0002);
        put_desc(32'h208, 32'h0400, 32'h2000_0005);
        put_desc(32'h400, 32'h1380, 32'h8000_0002);
        run_walk(32'h200, 0, "R7");
        chk(exp_ptr == 32'h408, "R7", "jump target pointer", exp_ptr, 32'h408);

        // R6 write direction, page and end flags together
        for (int i = 0; i < 5; i++) in_src.push_back(8'hA0 + i);
        put_desc(32'h500, 32'h2000, 32'h0000_0003);
        put_desc(32'h508, 32'h2100, 32'hC000_0002);
        run_walk(32'h500, 1, "R6");
        chk(rdb(32'h2101) == 8'hA4, "R6", "memory byte written", rdb(32'h2101), 8'hA4);
        chk(in_src.size() == 0, "R6", "all inbound bytes taken", in_src.size(), 0);
        wr_reg(2'd1, 32'h3);

        // R10 zero count
        stall = 0;
        put_desc(32'h600, 32'h3000, 32'h0000_0000);
        run_walk(32'h600, 0, "R10");
        wr_reg(2'd1, 32'h2);
        rd_reg(2'd1, v); chk(v == 0, "R10", "error flag cleared", v, 0);

        // R10 memory error during a data read
        err_en = 1; err_addr = 32'h1001;
        put_desc(32'h700, 32'h1000, 32'h8000_0003);
        run_walk(32'h700, 0, "R10");
        err_en = 0;
        wr_reg(2'd1, 32'h3);

        // R11 writes during a long walk are dropped
        stall = 2;
        put_desc(32'h800, 32'h1000, 32'h8000_0028);
        cur_tag = "R11";
        in_model = in_src;
        model_run(32'h800, 0);
        wr_reg(2'd2, 32'h800);
        wr_reg(2'd0, 32'h1);
        repeat (12) @(negedge clk);
        wr_reg(2'd2, 32'hDEAD_0000);
        wr_reg(2'd0, 32'h8);
        rd_reg(2'd0, v); chk(v == 32'h1, "R11", "command unchanged while busy", v, 1);
        rd_reg(2'd2, v); chk(v == 32'h808, "R11", "pointer unchanged while busy", v, 32'h808);
        begin
            int t = 0;
            while ((exp_acc.size() != 0 || exp_out.size() != 0) && t < 20000) begin
                @(negedge clk); t++;
            end
            chk(t < 20000, "R11", "walk completed", t, 0);
        end
        repeat (30) @(negedge clk);
        rd_reg(2'd2, v); chk(v == 32'h808, "R11", "final pointer", v, 32'h808);

        finish_sim();
    end
endmodule